// File: doc/BRIEF.md
# Secure Slot Arbiter for a Shared Bus

This arbiter hands a shared bus to two traffic classes, a protected class and an unprotected class, on a fixed schedule of time slots. A small frame of slots repeats without end. Each slot belongs to one class, and the ownership pattern comes from parameters. Every cycle the block looks at the current slot and the two request lines. It then issues at most one grant, reports which class owns the slot, and raises an idle flag when nobody is granted.

A mode input picks between two policies. Under the strict policy, a slot whose owner is not requesting is wasted. Under the recycling policy, an unprotected slot left unused may go to a waiting protected request. Recycling never works the other way round. As a result, what the unprotected class sees depends only on its own requests and the fixed schedule, and the protected class's timing cannot leak to it.

Top module: `secure_slot_arbiter`

## Requirements
- R1: A synchronous active-high reset sets the slot index to 0, whether the frame was just starting or partly done.
- R2: Outside reset, the slot index goes up by one every clock cycle. After slot FRAME_LEN-1 it returns to 0. With the default FRAME_LEN of 3 the sequence is 0,1,2,0,...
- R3: `slot_owner_sec` equals bit `slot_idx` of the parameter OWNER_MASK, where 1 means protected and 0 means unprotected. The default mask 3'b110 makes slot 0 unprotected and slots 1 and 2 protected.
- R4: In strict mode (`recycle_en`=0), the grant goes to the slot owner when the owner requests. When the owner does not request, no grant is issued, even if the other class is requesting.
- R5: In recycling mode (`recycle_en`=1), an unprotected slot with `req_ins`=0 and `req_sec`=1 is granted to the protected class.
- R6: The unprotected class is never granted during a protected slot, in either mode.
- R7: `grant` is a 2-bit vector: bit 0 is the unprotected grant and bit 1 is the protected grant. At most one bit is set in any cycle. The grant follows the requests and the slot index combinationally, within the same cycle.
- R8: `idle` is 1 exactly in the cycles in which `grant` is 2'b00.
- R9: The unprotected grant, `grant[0]`, does not depend on `req_sec` or `recycle_en`. It is 1 exactly when the slot is unprotected and `req_ins` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| recycle_en | input | 1 | 1 = one-sided recycling, 0 = strict time division |
| req_sec | input | 1 | Request from the protected class |
| req_ins | input | 1 | Request from the unprotected class |
| grant | output | 2 | bit0 unprotected grant, bit1 protected grant |
| slot_owner_sec | output | 1 | Current slot is owned by the protected class |
| slot_idx | output | $clog2(FRAME_LEN) | Current slot within the frame |
| idle | output | 1 | No grant is issued in this slot |

## Verification
The vector table walks several whole frames and applies all four request combinations in both modes. These patterns separate the strict policy from recycling: the two differ only when an unprotected slot sees a protected request and no unprotected request. A second sweep holds the unprotected request high while the protected request and the mode are flipped, so any path from protected traffic into the unprotected grant would show up. Directed cases cover a reset in the middle of a frame and the wrap from the last slot back to slot 0.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

    typedef enum logic {
        OWN_INS = 1'b0,
        OWN_SEC = 1'b1
    } owner_e;

    typedef enum logic {
        POL_STRICT  = 1'b0,
        POL_RECYCLE = 1'b1
    } policy_e;

    typedef struct packed {
        logic sec;
        logic ins;
    } grant_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ssa_slot_counter.sv
module ssa_slot_counter #(
    parameter int FRAME_LEN = 3,
    localparam int IW = ssa_pkg::idx_width(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [IW-1:0] slot
);
    localparam logic [IW-1:0] LAST = IW'(FRAME_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (slot == LAST)
            slot <= '0;
        else
            slot <= slot + 1'b1;
    end

    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (slot == LAST) |=> (slot == '0));
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (slot != LAST) |=> (slot == $past(slot) + 1'b1));
    p_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
        slot <= LAST);
endmodule

// File: rtl/ssa_owner_table.sv
module ssa_owner_table #(
    parameter int                   FRAME_LEN  = 3,
    parameter logic [FRAME_LEN-1:0] OWNER_MASK = 3'b110,
    localparam int IW = ssa_pkg::idx_width(FRAME_LEN)
) (
    input  logic            [IW-1:0] slot,
    output ssa_pkg::owner_e          owner
);
    ssa_pkg::owner_e table_q [FRAME_LEN];

    for (genvar g = 0; g < FRAME_LEN; g++) begin : g_slot
        assign table_q[g] = OWNER_MASK[g] ? ssa_pkg::OWN_SEC : ssa_pkg::OWN_INS;
    end

    always_comb begin
        owner = ssa_pkg::OWN_SEC;
        for (int k = 0; k < FRAME_LEN; k++)
            if (slot == IW'(k)) owner = table_q[k];
    end
endmodule

// File: rtl/ssa_grant_logic.sv
module ssa_grant_logic (
    input  logic             clk,
    input  logic             rst,
    input  ssa_pkg::owner_e  owner,
    input  ssa_pkg::policy_e policy,
    input  logic             req_sec,
    input  logic             req_ins,
    output ssa_pkg::grant_t  gnt
);
    import ssa_pkg::*;

    always_comb begin
        gnt = '0;
        if (owner == OWN_SEC) begin
            gnt.sec = req_sec;
        end else begin
            gnt.ins = req_ins;
            gnt.sec = (policy == POL_RECYCLE) && !req_ins && req_sec;
        end
    end

    p_one_grant_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gnt.sec, gnt.ins}));
    p_sec_slot_closed_r6: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_SEC) |-> !gnt.ins);
    p_strict_no_borrow_r4: assert property (@(posedge clk) disable iff (rst)
        (policy == POL_STRICT && owner == OWN_INS) |-> !gnt.sec);
    p_borrow_r5: assert property (@(posedge clk) disable iff (rst)
        (policy == POL_RECYCLE && owner == OWN_INS && !req_ins && req_sec) |-> gnt.sec);
    p_ins_view_r9: assert property (@(posedge clk) disable iff (rst)
        gnt.ins == (owner == OWN_INS && req_ins));
endmodule

// File: rtl/secure_slot_arbiter.sv
module secure_slot_arbiter #(
    parameter int                   FRAME_LEN  = 3,
    parameter logic [FRAME_LEN-1:0] OWNER_MASK = 3'b110
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        recycle_en,
    input  logic                                        req_sec,
    input  logic                                        req_ins,
    output logic [1:0]                                  grant,
    output logic                                        slot_owner_sec,
    output logic [ssa_pkg::idx_width(FRAME_LEN)-1:0]    slot_idx,
    output logic                                        idle
);
    import ssa_pkg::*;
    localparam int IW = idx_width(FRAME_LEN);

    logic [IW-1:0] slot;
    owner_e        owner;
    grant_t        gnt;
    policy_e       policy;

    assign policy = recycle_en ? POL_RECYCLE : POL_STRICT;

    ssa_slot_counter #(.FRAME_LEN(FRAME_LEN)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    ssa_owner_table #(.FRAME_LEN(FRAME_LEN), .OWNER_MASK(OWNER_MASK)) u_tbl (
        .slot  (slot),
        .owner (owner)
    );

    ssa_grant_logic u_gnt (
        .clk     (clk),
        .rst     (rst),
        .owner   (owner),
        .policy  (policy),
        .req_sec (req_sec),
        .req_ins (req_ins),
        .gnt     (gnt)
    );

    assign grant          = {gnt.sec, gnt.ins};
    assign slot_owner_sec = (owner == OWN_SEC);
    assign slot_idx       = slot;
    assign idle           = !(gnt.sec || gnt.ins);

    p_owner_served_r8: assert property (@(posedge clk) disable iff (rst)
        ((slot_owner_sec && req_sec) || (!slot_owner_sec && req_ins)) |-> !idle);
    p_reset_slot_r1: assert property (@(posedge clk)
        rst |=> (slot_idx == '0));
endmodule

// File: tb/tb_secure_slot_arbiter.sv
`timescale 1ns/1ps
module tb_secure_slot_arbiter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       recycle_en = 1'b0;
    logic       req_sec = 1'b0;
    logic       req_ins = 1'b0;
    logic [1:0] grant;
    logic       slot_owner_sec;
    logic [1:0] slot_idx;
    logic       idle;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    secure_slot_arbiter dut (
        .clk(clk), .rst(rst), .recycle_en(recycle_en),
        .req_sec(req_sec), .req_ins(req_ins),
        .grant(grant), .slot_owner_sec(slot_owner_sec),
        .slot_idx(slot_idx), .idle(idle)
    );

    // {recycle_en, req_sec, req_ins, exp_grant[1:0]}; slot = index mod 3
    localparam int NV = 14;
    localparam logic [4:0] VEC [NV] = '{
        5'b0_1_0_00,  // slot0 strict, only sec waiting: idle (R4)
        5'b0_0_1_00,  // slot1 strict, only ins waiting: idle (R4, R6)
        5'b0_1_1_10,  // slot2 sec owner
        5'b0_1_1_01,  // slot0 ins owner
        5'b1_0_1_00,  // slot1 recycle, ins never borrows (R6)
        5'b1_1_0_10,  // slot2
        5'b1_1_0_10,  // slot0 recycled to sec (R5)
        5'b1_1_1_10,  // slot1
        5'b1_0_0_00,  // slot2 nothing
        5'b1_1_1_01,  // slot0 owner wins over recycling
        5'b0_0_0_00,  // slot1
        5'b0_0_1_00,  // slot2 strict ins blocked
        5'b1_0_0_00,  // slot0 recycle nothing pending
        5'b0_1_0_10   // slot1
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", slot_idx, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            {recycle_en, req_sec, req_ins} = VEC[i][4:2];
            #1;
            check("R2", slot_idx, i % 3);
            check("R3", slot_owner_sec, (i % 3) != 0);
            check("R4_R5_R6_R7", grant, VEC[i][1:0]);
            check("R8", idle, VEC[i][1:0] == 2'b00);
            @(negedge clk);
        end

        // R9: unprotected grant independent of protected traffic and mode
        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < 3; s++) begin
                recycle_en = f[0];
                req_sec    = f[1];
                req_ins    = 1'b1;
                #1;
                check("R9", grant[0], slot_owner_sec == 1'b0);
                check("R7", (grant == 2'b11), 0);
                @(negedge clk);
            end
        end

        // R1: reset in mid frame
        req_sec = 0; req_ins = 0;
        while (slot_idx != 2'd1) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", slot_idx, 0);
        rst = 1'b0;
        #1;
        check("R1", slot_idx, 0);
        @(negedge clk);
        check("R2", slot_idx, 1);
        @(negedge clk);
        check("R2", slot_idx, 2);
        @(negedge clk);
        check("R2", slot_idx, 0);

        finish_run();
    end
endmodule